// File: doc/BRIEF.md
# Fetch, indirect and interrupt subcycle sequencer

This block is the control unit of a small accumulator machine that runs each instruction as a series of register-transfer steps on one synchronous memory port. It has four subcycles: fetch, indirect, execute and interrupt. In fetch it reads the instruction word at the program counter and bumps the counter by one. If the word asks for indirect addressing, it follows a pointer. In execute it performs a load, store, add or jump. Between instructions it can divert to a fixed handler address, after first pushing the return address onto a downward-growing stack in memory.

All memory traffic goes through an address register and a buffer register. The address port is always driven from the address register, and the write-data port is always driven from the buffer register. The memory returns read data one cycle after the read request. Interrupt delivery is gated by an enable bit. A one-cycle pulse on an input sets this bit, and entering the handler clears it. A two-bit output reports the subcycle the machine is in, so the step sequence can be followed from outside.

Top module: `subcycle_sequencer`

## Requirements
- R1: While reset is asserted and directly after it is released, the block is in fetch, with the program counter at 0, the accumulator at 0, the interrupt enable clear, and no memory request.
- R2: Fetch lasts 4 cycles. It issues one read at the program counter and leaves the program counter incremented by one (modulo 2^ADDR_W).
- R3: The instruction word has the opcode in bits [15:12], the indirect flag in bit 11 and the address field in bits [10:0]. With the flag set, an indirect subcycle of 3 cycles follows fetch. It reads the word at the address field, and the low 11 bits of that word become the effective address. With the flag clear, execute follows fetch directly and the effective address is the address field.
- R4: Opcode 1 (load) copies the word at the effective address into the accumulator. Its execute subcycle lasts 4 cycles.
- R5: Opcode 3 (add) adds the word at the effective address to the accumulator, modulo 2^16. Its execute subcycle lasts 4 cycles.
- R6: Opcode 2 (store) writes the accumulator to the effective address. Its execute subcycle lasts 2 cycles, and the write data equals the accumulator.
- R7: Opcode 4 (jump) loads the effective address into the program counter in a 1-cycle execute subcycle. Every other opcode completes execute in 1 cycle and changes no state.
- R8: If the interrupt request is high in the last execute cycle while the enable is set, a 2-cycle interrupt subcycle follows. It writes the zero-extended program counter to the stack location (initially SP_INIT) and decrements that location by one. It then loads HANDLER_ADDR into the program counter, clears the enable and returns to fetch.
- R9: A request seen while the enable is clear is ignored: execute goes straight to fetch, and the program counter keeps its value.
- R10: A one-cycle pulse on ie_set sets the interrupt enable. The enable stays set until an interrupt is taken.
- R11: A read and a write are never requested in the same cycle. The phase output encodes fetch as 0, indirect as 1, execute as 2 and interrupt as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| ie_set | input | 1 | Pulse that sets the interrupt enable |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| mem_addr | output | ADDR_W | Memory address (address register) |
| mem_wdata | output | DATA_W | Write data (buffer register) |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| phase | output | 2 | Current subcycle |
| pc_out | output | ADDR_W | Program counter |
| acc_out | output | DATA_W | Accumulator |
| ie_out | output | 1 | Interrupt enable |

## Verification
The assertions assume that memory answers every read on the following cycle. They also assume that ie_set is never pulsed in the last cycle of execute: at that edge the interrupt decision uses the enable value from before the pulse. The stimulus changes irq and pulses ie_set only in the first cycle of a fetch, so each request level stays constant across a whole instruction. The bench memory model always answers with one-cycle latency.

// File: rtl/seq_pkg.sv
package seq_pkg;
    parameter int OPC_W = 4;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_IND   = 2'd1,
        PH_EXEC  = 2'd2,
        PH_INTR  = 2'd3
    } phase_e;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd4;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic [DATA_W-1:0] ir,
    output logic              is_load,
    output logic              is_store,
    output logic              is_add,
    output logic              is_jump,
    output logic              ind,
    output logic [ADDR_W-1:0] field
);
    localparam int IND_POS = ADDR_W;
    localparam int OPC_POS = ADDR_W + 1;

    logic [OPC_W-1:0] opc;

    assign opc      = ir[OPC_POS +: OPC_W];
    assign ind      = ir[IND_POS];
    assign field    = ir[ADDR_W-1:0];
    assign is_load  = (opc == OPC_LOAD);
    assign is_store = (opc == OPC_STORE);
    assign is_add   = (opc == OPC_ADD);
    assign is_jump  = (opc == OPC_JUMP);
endmodule

// File: rtl/seq_accum.sv
module seq_accum #(
    parameter int DATA_W = 16
) (
    input  logic              sel_add,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_next
);
    logic [DATA_W-1:0] sum;

    assign sum      = acc + operand;
    assign acc_next = sel_add ? sum : operand;
endmodule

// File: rtl/subcycle_sequencer.sv
module subcycle_sequencer
    import seq_pkg::*;
#(
    parameter int                DATA_W       = 16,
    parameter int                ADDR_W       = 11,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h040,
    parameter logic [ADDR_W-1:0] SP_INIT      = 11'h7FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic              ie_set,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [1:0]        phase,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] acc_out,
    output logic              ie_out
);
    localparam int             IND_BIT = ADDR_W;
    localparam int             PAD_W   = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [1:0]        step;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [ADDR_W-1:0] sp;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic              ie;
    } state_t;

    state_t st_q, st_d;
    logic   rd_d, wr_d, done_d;

    logic              dec_load, dec_store, dec_add, dec_jump, dec_ind;
    logic [ADDR_W-1:0] dec_field;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] acc_next;

    seq_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .ir       (st_q.ir),
        .is_load  (dec_load),
        .is_store (dec_store),
        .is_add   (dec_add),
        .is_jump  (dec_jump),
        .ind      (dec_ind),
        .field    (dec_field)
    );

    seq_accum #(.DATA_W(DATA_W)) u_accum (
        .sel_add  (dec_add),
        .acc      (st_q.acc),
        .operand  (st_q.mbr),
        .acc_next (acc_next)
    );

    // Indirect: pointer left in the buffer register; direct: instruction field
    assign ea = dec_ind ? st_q.mbr[ADDR_W-1:0] : dec_field;

    always_comb begin
        st_d   = st_q;
        rd_d   = 1'b0;
        wr_d   = 1'b0;
        done_d = 1'b0;
        if (ie_set) st_d.ie = 1'b1;

        unique case (st_q.phase)
            PH_FETCH: begin
                unique case (st_q.step)
                    2'd0: begin
                        st_d.mar  = st_q.pc;
                        st_d.step = 2'd1;
                    end
                    2'd1: begin
                        rd_d      = 1'b1;
                        st_d.pc   = st_q.pc + ONE_A;
                        st_d.step = 2'd2;
                    end
                    2'd2: begin
                        st_d.mbr  = mem_rdata;
                        st_d.step = 2'd3;
                    end
                    default: begin
                        st_d.ir    = st_q.mbr;
                        st_d.step  = 2'd0;
                        st_d.phase = st_q.mbr[IND_BIT] ? PH_IND : PH_EXEC;
                    end
                endcase
            end
            PH_IND: begin
                unique case (st_q.step)
                    2'd0: begin
                        st_d.mar  = st_q.mbr[ADDR_W-1:0];
                        st_d.step = 2'd1;
                    end
                    2'd1: begin
                        rd_d      = 1'b1;
                        st_d.step = 2'd2;
                    end
                    default: begin
                        st_d.mbr   = mem_rdata;
                        st_d.step  = 2'd0;
                        st_d.phase = PH_EXEC;
                    end
                endcase
            end
            PH_EXEC: begin
                if (dec_jump) begin
                    st_d.pc = ea;
                    done_d  = 1'b1;
                end else if (dec_store) begin
                    if (st_q.step == 2'd0) begin
                        st_d.mar  = ea;
                        st_d.mbr  = st_q.acc;
                        st_d.step = 2'd1;
                    end else begin
                        wr_d   = 1'b1;
                        done_d = 1'b1;
                    end
                end else if (dec_load || dec_add) begin
                    unique case (st_q.step)
                        2'd0: begin
                            st_d.mar  = ea;
                            st_d.step = 2'd1;
                        end
                        2'd1: begin
                            rd_d      = 1'b1;
                            st_d.step = 2'd2;
                        end
                        2'd2: begin
                            st_d.mbr  = mem_rdata;
                            st_d.step = 2'd3;
                        end
                        default: begin
                            st_d.acc = acc_next;
                            done_d   = 1'b1;
                        end
                    endcase
                end else begin
                    done_d = 1'b1;
                end
                if (done_d) begin
                    st_d.step  = 2'd0;
                    st_d.phase = (irq && st_q.ie) ? PH_INTR : PH_FETCH;
                end
            end
            default: begin
                if (st_q.step == 2'd0) begin
                    st_d.mbr  = {{PAD_W{1'b0}}, st_q.pc};
                    st_d.mar  = st_q.sp;
                    st_d.step = 2'd1;
                end else begin
                    wr_d       = 1'b1;
                    st_d.sp    = st_q.sp - ONE_A;
                    st_d.pc    = HANDLER_ADDR;
                    st_d.ie    = 1'b0;
                    st_d.step  = 2'd0;
                    st_d.phase = PH_FETCH;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_FETCH;
            st_q.step  <= 2'd0;
            st_q.pc    <= '0;
            st_q.mar   <= '0;
            st_q.sp    <= SP_INIT;
            st_q.mbr   <= '0;
            st_q.ir    <= '0;
            st_q.acc   <= '0;
            st_q.ie    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.mar;
    assign mem_wdata = st_q.mbr;
    assign mem_rd    = rd_d;
    assign mem_wr    = wr_d;
    assign phase     = st_q.phase;
    assign pc_out    = st_q.pc;
    assign acc_out   = st_q.acc;
    assign ie_out    = st_q.ie;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
#(
    parameter int                DATA_W       = 16,
    parameter int                ADDR_W       = 11,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h040
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] pc_out,
    input logic [DATA_W-1:0] acc_out,
    input logic              ie_out
);
    localparam int PAD_W = DATA_W - ADDR_W;

    assert_no_rd_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_fetch_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && mem_rd) |=> (pc_out == $past(mem_addr) + ADDR_W'(1)));

    assert_ind_to_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IND) |=> (phase == PH_IND || phase == PH_EXEC));

    assert_store_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && mem_wr) |-> (mem_wdata == acc_out));

    assert_push_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INTR && mem_wr) |-> (mem_wdata == {{PAD_W{1'b0}}, pc_out}));

    assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INTR && mem_wr) |=> (pc_out == HANDLER_ADDR && !ie_out && phase == PH_FETCH));

    assert_masked_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && !ie_out) |=> (phase != PH_INTR));
endmodule

bind subcycle_sequencer seq_checker #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR)
) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .phase     (phase),
    .pc_out    (pc_out),
    .acc_out   (acc_out),
    .ie_out    (ie_out)
);

// File: tb/subcycle_sequencer_bench.sv
module subcycle_sequencer_bench;
    localparam int DW = 16;
    localparam int AW = 11;
    localparam int DEPTH = 2048;
    localparam int NINSTR = 1500;
    localparam logic [AW-1:0] HND = 11'h040;
    localparam logic [AW-1:0] SPI = 11'h7FF;
    localparam int PF = 0, PI = 1, PE = 2, PQ = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, irq, ie_set;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd, mem_wr;
    logic [1:0]    phase;
    logic [AW-1:0] pc_out;
    logic [DW-1:0] acc_out;
    logic          ie_out;

    subcycle_sequencer #(.DATA_W(DW), .ADDR_W(AW), .HANDLER_ADDR(HND), .SP_INIT(SPI)) u_subcycle_sequencer (
        .clk(clk), .rst_n(rst_n), .irq(irq), .ie_set(ie_set), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .phase(phase), .pc_out(pc_out), .acc_out(acc_out), .ie_out(ie_out)
    );

    logic [DW-1:0] dmem [DEPTH];
    logic [DW-1:0] mmem [DEPTH];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= dmem[mem_addr];
        if (mem_wr) dmem[mem_addr] <= mem_wdata;
    end

    int checks = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exec_cycles(input logic [3:0] opc);
        case (opc)
            4'd1, 4'd3: return 4;
            4'd2:       return 2;
            default:    return 1;
        endcase
    endfunction

    function automatic logic [DW-1:0] mk(input logic [3:0] opc, input bit ind, input logic [AW-1:0] a);
        return {opc, ind, a};
    endfunction

    // reference model state and per-instruction expectations
    logic [AW-1:0] m_pc, m_sp;
    logic [DW-1:0] m_acc;
    bit            m_ie;
    bit            e_ind, e_intr, e_store, e_ign, e_ie;
    int            e_len;
    logic [3:0]    e_opc;
    logic [AW-1:0] e_ea, e_pc_fetch, e_pc_exec, e_saved, e_spold;
    logic [DW-1:0] e_acc;

    task automatic model_step(input bit irq_now);
        logic [DW-1:0] w;
        w          = mmem[m_pc];
        m_pc       = m_pc + 1'b1;
        e_pc_fetch = m_pc;
        e_opc      = w[15:12];
        e_ind      = w[11];
        e_ea       = w[10:0];
        if (e_ind) e_ea = mmem[e_ea][AW-1:0];
        e_len   = exec_cycles(e_opc);
        e_store = 1'b0;
        case (e_opc)
            4'd1: m_acc = mmem[e_ea];
            4'd3: m_acc = m_acc + mmem[e_ea];
            4'd2: begin mmem[e_ea] = m_acc; e_store = 1'b1; end
            4'd4: m_pc = e_ea;
            default: ;
        endcase
        e_acc     = m_acc;
        e_pc_exec = m_pc;
        e_ie      = m_ie;
        e_intr    = irq_now && m_ie;
        e_ign     = irq_now && !m_ie;
        if (e_intr) begin
            e_saved    = m_pc;
            e_spold    = m_sp;
            mmem[m_sp] = {5'b0, m_pc};
            m_sp       = m_sp - 1'b1;
            m_pc       = HND;
            m_ie       = 1'b0;
        end
    endtask

    task automatic start_instr(input int idx);
        bit s;
        case (idx)
            0: begin irq = 1'b1; s = 1'b0; end
            1: begin irq = 1'b0; s = 1'b1; end
            2: begin irq = 1'b0; s = 1'b0; end
            3: begin irq = 1'b1; s = 1'b0; end
            4: begin irq = 1'b1; s = 1'b0; end
            default: begin
                irq = ($urandom % 4) == 0;
                s   = ($urandom % 3) == 0;
            end
        endcase
        if (s) begin
            ie_set = 1'b1;
            m_ie   = 1'b1;
        end
        model_step(irq);
    endtask

    initial begin
        #(10 * 200000);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int  prev, cur, len, idx;
        bit  done;
        void'($urandom(32'h5EED1234));
        irq = 1'b0; ie_set = 1'b0; rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            int r;
            logic [3:0] op;
            r = int'($urandom % 8);
            case (r)
                0, 1:    op = 4'd1;
                2:       op = 4'd2;
                3, 4:    op = 4'd3;
                5:       op = 4'd4;
                6:       op = 4'd0;
                default: op = 4'(5 + ($urandom % 11));
            endcase
            dmem[i] = mk(op, ($urandom % 3) == 0, AW'($urandom));
        end
        // directed: indirect load, wrapping add, indirect store, direct jump
        dmem[0]     = mk(4'd1, 1'b1, 11'h100);
        dmem[1]     = mk(4'd3, 1'b0, 11'h201);
        dmem[2]     = mk(4'd2, 1'b1, 11'h100);
        dmem[3]     = mk(4'd4, 1'b0, 11'h010);
        dmem[11'h100] = 16'h0200;
        dmem[11'h200] = 16'hFFFF;
        dmem[11'h201] = 16'h0003;
        for (int i = 0; i < DEPTH; i++) mmem[i] = dmem[i];
        m_pc = '0; m_sp = SPI; m_acc = '0; m_ie = 1'b0;

        repeat (3) @(negedge clk);
        check(int'(phase) == PF, "R1 phase in reset", phase, PF);
        check(pc_out == '0, "R1 pc in reset", pc_out, 0);
        check(acc_out == '0, "R1 acc in reset", acc_out, 0);
        check(!ie_out, "R1 enable in reset", ie_out, 0);
        check(!mem_rd && !mem_wr, "R1 no request in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        check(int'(phase) == PF && pc_out == '0, "R1 state at release", pc_out, 0);

        idx = 0; prev = PF; len = 1; done = 1'b0;
        start_instr(0);
        while (!done) begin
            @(negedge clk);
            ie_set = 1'b0;
            check(!(mem_rd && mem_wr), "R11 read and write together", {mem_rd, mem_wr}, 0);
            cur = int'(phase);
            if (cur == prev) begin
                len++;
                if (len > 20) begin
                    check(1'b0, "R2 subcycle stuck", len, 4);
                    done = 1'b1;
                end
            end else begin
                case (prev)
                    PF: begin
                        check(len == 4, "R2 fetch length", len, 4);
                        check(pc_out == e_pc_fetch, "R2 pc after fetch", pc_out, e_pc_fetch);
                        check(ie_out == e_ie, "R10 enable after pulse", ie_out, e_ie);
                        check(cur == (e_ind ? PI : PE), "R3 successor of fetch", cur, e_ind ? PI : PE);
                    end
                    PI: begin
                        check(len == 3, "R3 indirect length", len, 3);
                        check(cur == PE, "R3 successor of indirect", cur, PE);
                    end
                    PE: begin
                        if (e_opc == 4'd1) check(acc_out == e_acc, "R4 load result", acc_out, e_acc);
                        else if (e_opc == 4'd3) check(acc_out == e_acc, "R5 add result", acc_out, e_acc);
                        else check(acc_out == e_acc, "R7 acc unchanged", acc_out, e_acc);
                        if (e_store) check(dmem[e_ea] == e_acc, "R6 stored word", dmem[e_ea], e_acc);
                        check(pc_out == e_pc_exec, "R7 pc after execute", pc_out, e_pc_exec);
                        check(len == e_len, "R7 execute length", len, e_len);
                        if (e_ign) check(cur == PF, "R9 masked request ignored", cur, PF);
                        else check(cur == (e_intr ? PQ : PF), "R8 successor of execute", cur, e_intr ? PQ : PF);
                    end
                    default: begin
                        check(len == 2, "R8 interrupt length", len, 2);
                        check(cur == PF, "R8 return to fetch", cur, PF);
                        check(pc_out == HND, "R8 handler address", pc_out, HND);
                        check(!ie_out, "R8 enable cleared", ie_out, 0);
                        check(dmem[e_spold] == {5'b0, e_saved}, "R8 saved pc", dmem[e_spold], {5'b0, e_saved});
                    end
                endcase
                if (cur == PF) begin
                    idx++;
                    if (idx >= NINSTR) done = 1'b1;
                    else start_instr(idx);
                end
                prev = cur;
                len  = 1;
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule